// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block holds the error reporting state of a CAN controller. A protocol engine delivers single-cycle pulses: one vector for the error factors (bus lock, bus-off entry and recovery, error passive, warning and so on) and one for the detailed cause of a bus error (stuff, form, CRC, ACK, bit errors). The block latches these pulses into flag registers. Software reads them and clears each flag by writing a 0 to its position. Writing 1 leaves a flag as it is.

A per-factor enable mask and a global error-interrupt enable decide whether the latched factors raise the single error interrupt request. The request is also visible as bit 5 of a read-only interrupt status register. A display-mode bit in the code register selects how cause codes are kept. In accumulate mode every new cause is added to the ones already held. In latest-only mode each new event replaces the older codes. The transmit and receive error counter values produced by the engine are captured for byte-wide readback.

Top module: `can_err_capture`

## Requirements
- R1: After reset every flag, enable, the display-mode bit and the captured counters are 0, the interrupt request is low and all register reads at offsets 0 to 7 return 0.
- R2: A pulse on factor event bit i sets factor flag i, which reads back at offset 0 from the next cycle on. Bit 7 is bus lock, bit 6 overload frame sent, bit 5 receive overrun, bit 4 bus-off recovery, bit 3 bus-off entry, bit 2 error passive, bit 1 error warning and bit 0 bus error.
- R3: A write to offset 0 clears every factor flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag is set after that cycle.
- R5: The code register at offset 2 holds cause flags in bits 6..0. Bit 6 is ACK delimiter error, bit 5 dominant bit error, bit 4 recessive bit error, bit 3 CRC error, bit 2 ACK error, bit 1 form error and bit 0 stuff error. A write clears each cause flag whose data bit is 0, and an event on the same flag in that cycle wins.
- R6: Bit 7 of offset 2 is the display-mode bit, written and read directly. When it is 1, new cause events are OR-ed into the cause flags already held.
- R7: When the display-mode bit is 0, a cycle with any cause event leaves exactly the causes of that event in bits 6..0 and drops the older ones.
- R8: The error interrupt request is high exactly when bit 5 of the interrupt enable register (offset 3) is 1 and some factor flag is set whose bit in the factor enable register (offset 1) is 1. It stays high for as long as that holds, and bit 5 of the status register (offset 4) shows the same value.
- R9: Offsets 5 and 6 return the transmit and receive error counter inputs as they were one clock cycle earlier.
- R10: Offsets 1 and 3 read back the last byte written. Writes to offsets 4, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fact_evt | input | 8 | Error factor event pulses, one bit per factor |
| code_evt | input | 7 | Bus error cause event pulses |
| tx_cnt_in | input | 8 | Transmit error counter value from the engine |
| rx_cnt_in | input | 8 | Receive error counter value from the engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| err_irq | output | 1 | Error interrupt request |

## Verification
On every cycle, the assertions check that each flag bit obeys its set, clear, flush and hold rules. They also check that latest-only mode leaves nothing older than the current event, that the interrupt request never rises without a latched flag or with the global enable off, and that the captured counters trail their inputs by one cycle. Only the bench scenarios can show full register behaviour as software sees it. That covers the exact bit positions of each factor and cause, a clearing write racing an event on the same bit, and switching between display modes while codes are held. It also covers the interrupt combining factor and global enables, and writes to read-only offsets changing nothing.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned OFS_FACT = 0;
   localparam int unsigned OFS_FEN  = 1;
   localparam int unsigned OFS_CODE = 2;
   localparam int unsigned OFS_IEN  = 3;
   localparam int unsigned OFS_IST  = 4;
   localparam int unsigned OFS_TXC  = 5;
   localparam int unsigned OFS_RXC  = 6;
   localparam int unsigned IRQ_BIT  = 5;
   localparam int unsigned MODE_BIT = 7;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         flush_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] flags_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("err_flag_bank: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic drop;
      assign drop = flush_i || (wr_i && !wdata_i[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags_o[i] <= 1'b0;
         else if (set_i[i])   flags_o[i] <= 1'b1;
         else if (drop)       flags_o[i] <= 1'b0;
      end

      // R2 / R4: an event always leaves the flag set
      p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_o[i]);
      // R3: zero written with no event clears
      p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && !wdata_i[i] && !set_i[i]) |=> !flags_o[i]);
      // R3: nothing touching the bit keeps it
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !flush_i && !(wr_i && !wdata_i[i])) |=> $stable(flags_o[i]));
   end
endmodule

// File: rtl/err_code_store.sv
module err_code_store #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] evt_i,
   input  logic              wr_i,
   input  logic [7:0]        wdata_i,
   output logic              accum_o,
   output logic [CODE_W-1:0] code_o
);
   import can_err_pkg::*;

   generate
      if (CODE_W < 1 || CODE_W > MODE_BIT) begin : g_bad_w
         $error("err_code_store: CODE_W must be 1..7");
      end
   endgenerate

   logic flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    accum_o <= 1'b0;
      else if (wr_i) accum_o <= wdata_i[MODE_BIT];
   end

   // latest-only mode: a fresh event wipes older causes
   assign flush = !accum_o && (|evt_i);

   err_flag_bank #(.W(CODE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_i),
      .flush_i (flush),
      .wr_i    (wr_i),
      .wdata_i (wdata_i[CODE_W-1:0]),
      .flags_o (code_o)
   );

   // R7: in latest-only mode nothing older than the event survives
   p_latest_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!accum_o && (|evt_i)) |=> ((code_o & ~$past(evt_i)) == '0));
   // R6: in accumulate mode held causes survive an event without a write
   p_accumulate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accum_o && !wr_i) |=> ((code_o & $past(code_o)) == $past(code_o)));
endmodule

// File: rtl/err_irq_combine.sv
module err_irq_combine #(
   parameter int unsigned FACT_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FACT_W-1:0] flags_i,
   input  logic [FACT_W-1:0] en_i,
   input  logic              glob_en_i,
   output logic              irq_o
);
   logic req;
   assign req = glob_en_i && (|(flags_i & en_i));

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req;
         end
      end else begin : g_comb
         assign irq_o = req;
         // R8: a raised request is always backed by a latched flag
         p_irq_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> (flags_i != '0));
      end
   endgenerate
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned FACT_W   = 8,
   parameter int unsigned CODE_W   = 7,
   parameter int unsigned CNT_W    = 8,
   parameter bit          SYNC_CNT = 1'b1,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FACT_W-1:0] fact_evt,
   input  logic [CODE_W-1:0] code_evt,
   input  logic [CNT_W-1:0]  tx_cnt_in,
   input  logic [CNT_W-1:0]  rx_cnt_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              err_irq
);
   import can_err_pkg::*;

   generate
      if (ADDR_W < 3)                  begin : g_bad_addr
         $error("can_err_capture: ADDR_W must cover 7 offsets");
      end
      if (FACT_W < 1 || FACT_W > BYTE_W) begin : g_bad_fact
         $error("can_err_capture: FACT_W must be 1..8");
      end
      if (CNT_W < 1 || CNT_W > BYTE_W)   begin : g_bad_cnt
         $error("can_err_capture: CNT_W must be 1..8");
      end
   endgenerate

   logic              sel_fact, sel_fen, sel_code, sel_ien;
   logic [FACT_W-1:0] fact_flags;
   logic [FACT_W-1:0] fact_en;
   logic [7:0]        int_en;
   logic [CODE_W-1:0] code_flags;
   logic              accum;
   logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q;

   assign sel_fact = reg_wr && (reg_addr == ADDR_W'(OFS_FACT));
   assign sel_fen  = reg_wr && (reg_addr == ADDR_W'(OFS_FEN));
   assign sel_code = reg_wr && (reg_addr == ADDR_W'(OFS_CODE));
   assign sel_ien  = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));

   err_flag_bank #(.W(FACT_W)) u_fact (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (fact_evt),
      .flush_i (1'b0),
      .wr_i    (sel_fact),
      .wdata_i (reg_wdata[FACT_W-1:0]),
      .flags_o (fact_flags)
   );

   err_code_store #(.CODE_W(CODE_W)) u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (code_evt),
      .wr_i    (sel_code),
      .wdata_i (reg_wdata),
      .accum_o (accum),
      .code_o  (code_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fact_en <= '0;
         int_en  <= '0;
      end else begin
         if (sel_fen) fact_en <= reg_wdata[FACT_W-1:0];
         if (sel_ien) int_en  <= reg_wdata;
      end
   end

   err_irq_combine #(.FACT_W(FACT_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (fact_flags),
      .en_i      (fact_en),
      .glob_en_i (int_en[IRQ_BIT]),
      .irq_o     (err_irq)
   );

   generate
      if (SYNC_CNT) begin : g_cnt_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_cnt_q <= '0;
               rx_cnt_q <= '0;
            end else begin
               tx_cnt_q <= tx_cnt_in;
               rx_cnt_q <= rx_cnt_in;
            end
         end
         // R9: captured counters trail inputs by one cycle
         p_cnt_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (tx_cnt_q == $past(tx_cnt_in) && rx_cnt_q == $past(rx_cnt_in)));
      end else begin : g_cnt_pass
         assign tx_cnt_q = tx_cnt_in;
         assign rx_cnt_q = rx_cnt_in;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_FACT): reg_rdata[FACT_W-1:0] = fact_flags;
         ADDR_W'(OFS_FEN):  reg_rdata[FACT_W-1:0] = fact_en;
         ADDR_W'(OFS_CODE): begin
            reg_rdata[CODE_W-1:0] = code_flags;
            reg_rdata[MODE_BIT]   = accum;
         end
         ADDR_W'(OFS_IEN):  reg_rdata = int_en;
         ADDR_W'(OFS_IST):  reg_rdata[IRQ_BIT] = err_irq;
         ADDR_W'(OFS_TXC):  reg_rdata[CNT_W-1:0] = tx_cnt_q;
         ADDR_W'(OFS_RXC):  reg_rdata[CNT_W-1:0] = rx_cnt_q;
         default:           reg_rdata = '0;
      endcase
   end

   // R8: no request while the global enable is off
   p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en[IRQ_BIT] |-> !err_irq);
   // R10: enable registers change only on their own write
   p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_fen && !sel_ien) |=> ($stable(fact_en) && $stable(int_en)));
endmodule

// File: tb/sim_can_err_capture.sv
`timescale 1ns/1ps
module sim_can_err_capture;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] fact_evt = '0;
   logic [6:0] code_evt = '0;
   logic [7:0] tx_cnt_in = '0, rx_cnt_in = '0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       err_irq;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   can_err_capture u0 (
      .clk(clk), .rst_n(rst_n), .fact_evt(fact_evt), .code_evt(code_evt),
      .tx_cnt_in(tx_cnt_in), .rx_cnt_in(rx_cnt_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .err_irq(err_irq)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic fevt(input logic [7:0] f);
      @(negedge clk);
      fact_evt = f;
      @(negedge clk);
      fact_evt = '0;
   endtask

   task automatic cevt(input logic [6:0] c);
      @(negedge clk);
      code_evt = c;
      @(negedge clk);
      code_evt = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check($sformatf("R1 offset %0d", a), d, 8'h00);
      end
      check("R1 irq", {7'b0, err_irq}, 8'h00);
   endtask

   task automatic t_factor();
      logic [7:0] d;
      fevt(8'h81);
      rd(0, d); check("R2 bus lock+bus error", d, 8'h81);
      fevt(8'h24);
      rd(0, d); check("R2 overrun+passive", d, 8'hA5);
      wr(0, 8'h7F);
      rd(0, d); check("R3 clear bit7 only", d, 8'h25);
      wr(0, 8'hFB);
      rd(0, d); check("R3 clear bit2 only", d, 8'h21);
      wr(0, 8'hFF);
      rd(0, d); check("R3 all ones keeps", d, 8'h21);
      wr(0, 8'h00);
      rd(0, d); check("R3 clear all", d, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 0; reg_wdata = 8'h00; fact_evt = 8'h09;
      @(negedge clk);
      reg_wr = 1'b0; fact_evt = '0;
      rd(0, d); check("R4 event beats clear", d, 8'h09);
      wr(0, 8'h00);
      rd(0, d); check("R4 later clear", d, 8'h00);
   endtask

   task automatic t_code();
      logic [7:0] d;
      cevt(7'h08);
      rd(2, d); check("R7 crc latest", d, 8'h08);
      cevt(7'h01);
      rd(2, d); check("R7 stuff replaces crc", d, 8'h01);
      wr(2, 8'h80);
      rd(2, d); check("R6 mode set, causes cleared", d, 8'h80);
      cevt(7'h20);
      cevt(7'h04);
      rd(2, d); check("R6 accumulate", d, 8'hA4);
      wr(2, 8'hDF);
      rd(2, d); check("R5 clear dominant bit error", d, 8'h84);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2; reg_wdata = 8'h80; code_evt = 7'h40;
      @(negedge clk);
      reg_wr = 1'b0; code_evt = '0;
      rd(2, d); check("R5 cause event beats clear", d, 8'hC0);
      wr(2, 8'h00);
      rd(2, d); check("R5 clear all and mode off", d, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      fevt(8'h08);
      check("R8 no enables", {7'b0, err_irq}, 8'h00);
      wr(1, 8'h08);
      check("R8 global enable off", {7'b0, err_irq}, 8'h00);
      wr(3, 8'h20);
      rd(4, d); check("R8 status set", d, 8'h20);
      check("R8 irq high", {7'b0, err_irq}, 8'h01);
      fevt(8'h02);
      wr(0, 8'hFD);
      check("R8 stays while flag set", {7'b0, err_irq}, 8'h01);
      wr(0, 8'h00);
      rd(4, d); check("R8 status drop", d, 8'h00);
      fevt(8'h02);
      check("R8 unenabled factor", {7'b0, err_irq}, 8'h00);
      wr(0, 8'h00);
   endtask

   task automatic t_cnt();
      logic [7:0] d;
      @(negedge clk);
      tx_cnt_in = 8'h5A; rx_cnt_in = 8'hC3;
      reg_addr = 5;
      #1 check("R9 tx not yet", reg_rdata, 8'h00);
      rd(5, d); check("R9 tx counter", d, 8'h5A);
      rd(6, d); check("R9 rx counter", d, 8'hC3);
   endtask

   task automatic t_ignore();
      logic [7:0] d;
      wr(1, 8'h3C);
      rd(1, d); check("R10 factor enable readback", d, 8'h3C);
      rd(3, d); check("R10 int enable readback", d, 8'h20);
      wr(4, 8'hFF); wr(5, 8'h00); wr(6, 8'h11); wr(7, 8'hFF);
      rd(4, d); check("R10 status ignores write", d, 8'h00);
      rd(5, d); check("R10 tx ignores write", d, 8'h5A);
      rd(6, d); check("R10 rx ignores write", d, 8'hC3);
      rd(7, d); check("R10 offset 7", d, 8'h00);
      rd(0, d); check("R10 flags untouched", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_factor();
      t_collide();
      t_code();
      t_irq();
      t_cnt();
      t_ignore();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule